// File: doc/BRIEF.md
# Serial Mouse Packet Encoder

This block turns one sample of mouse motion and button state into a five-byte packet for a serial pointing-device stream and places the packet into a byte queue. A sample is presented with a single-cycle strobe, together with signed X and Y deltas and three button levels. A consuming serial channel drains the queue one byte at a time through a valid/ready handshake.

The packet opens with a header byte in which the button states appear as active-low bits. The X delta follows, then the Y delta with its sign flipped. Both deltas are clamped to a symmetric signed 8-bit range. Two zero bytes close the packet. The queue only takes a whole packet. A sample that arrives when fewer than five entries are free is discarded, so a packet is never split.

Top module: `mouse_pkt_enc`

## Requirements
- R1: After reset the queue is empty: byte_valid_o is 0 and byte_o is 0x00.
- R2: Byte 0 of a packet is 0x87 with bit 2 cleared if left is pressed, bit 1 cleared if middle is pressed and bit 0 cleared if right is pressed (button input 1 = pressed).
- R3: Byte 1 is dx clamped to -127..+127, in 8-bit two's complement (for example 200 gives 0x7F, -128 gives 0x81).
- R4: Byte 2 is the negation of dy clamped to -127..+127, in 8-bit two's complement (for example dy = 10 gives 0xF6, dy = -32768 gives 0x7F).
- R5: Bytes 3 and 4 of every packet are 0x00.
- R6: Bytes leave in packet order (bytes 0 to 4), and packets leave in the order of their accepted strobes. Each handshake (valid and ready both high at a clock edge) removes exactly one byte.
- R7: The queue holds 256 bytes. A strobe is accepted only when at least 5 entries are free; otherwise no byte of that packet is stored.
- R8: While the queue is empty, byte_valid_o is 0 and byte_o reads 0x00. Asserting ready while the queue is empty has no effect.
- R9: After a handshake, if bytes remain, the next byte is valid in the following cycle, so a continuously ready consumer sees no gaps.
- R10: A strobe and a handshake in the same cycle both take effect. The free-space test uses the fill level before the pop.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_valid_i | input | 1 | One-cycle strobe presenting a new sample |
| dx_i | input | DELTA_W | Signed X movement |
| dy_i | input | DELTA_W | Signed Y movement |
| btn_left_i | input | 1 | Left button pressed |
| btn_mid_i | input | 1 | Middle button pressed |
| btn_right_i | input | 1 | Right button pressed |
| byte_o | output | 8 | Byte at the head of the queue, 0x00 when empty |
| byte_valid_o | output | 1 | The queue holds at least one byte |
| byte_ready_i | input | 1 | Consumer takes byte_o at this edge |

## Verification
The encoder is driven with in-range deltas, deltas at ±127 and one step beyond, deltas at the extremes of the input width, and every button combination of interest. These separate a wrong clamp boundary, a missing Y inversion and a swapped button bit. Packets are queued back to back and drained by a consumer that stays ready, which exposes wrong byte order and gaps after a pop. The queue is then filled to 255 bytes, where the next strobe must be discarded whole. Further cases cover a strobe and a pop in the same cycle, and ready while the queue is empty, which catch an off-by-one in the free-space test and a read of a stale entry.

// File: rtl/mpkt_pkg.sv
package mpkt_pkg;
  localparam int PKT_LEN = 5;
  localparam logic [7:0] HDR_BASE = 8'h87;
  typedef logic [7:0] byte_t;
endpackage

// File: rtl/mpkt_encoder.sv
module mpkt_encoder
  import mpkt_pkg::*;
#(
  parameter int DELTA_W = 16
) (
  input  logic signed [DELTA_W-1:0] dx_i,
  input  logic signed [DELTA_W-1:0] dy_i,
  input  logic                      btn_left_i,
  input  logic                      btn_mid_i,
  input  logic                      btn_right_i,
  output logic [PKT_LEN-1:0][7:0]   pkt_o
);
  localparam int EW = DELTA_W + 1;
  localparam logic signed [EW-1:0] LIM_HI = EW'(127);
  localparam logic signed [EW-1:0] LIM_LO = -EW'(127);

  function automatic byte_t clamp8(input logic signed [EW-1:0] v);
    if (v > LIM_HI)      return 8'h7f;
    else if (v < LIM_LO) return 8'h81;
    else                 return v[7:0];
  endfunction

  logic signed [EW-1:0] dx_ext, dy_neg;

  always_comb begin
    dx_ext = {dx_i[DELTA_W-1], dx_i};
    // extra bit keeps the negation of the most negative input exact
    dy_neg = -{dy_i[DELTA_W-1], dy_i};
  end

  assign pkt_o[0] = HDR_BASE & ~{5'b0, btn_left_i, btn_mid_i, btn_right_i};
  assign pkt_o[1] = clamp8(dx_ext);
  assign pkt_o[2] = clamp8(dy_neg);

  for (genvar k = 3; k < PKT_LEN; k++) begin : g_tail
    assign pkt_o[k] = '0;
  end
endmodule

// File: rtl/mpkt_fifo.sv
module mpkt_fifo
  import mpkt_pkg::*;
#(
  parameter int DEPTH = 256
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    push_i,
  input  logic [PKT_LEN-1:0][7:0] pkt_i,
  input  logic                    ready_i,
  output logic [7:0]              byte_o,
  output logic                    valid_o
);
  // DEPTH must be a power of two: pointers wrap by overflow
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] PKT_CNT  = CW'(PKT_LEN);
  localparam logic [CW-1:0] ROOM_MAX = CW'(DEPTH - PKT_LEN);
  localparam logic [CW-1:0] DEPTH_C  = CW'(DEPTH);

  byte_t         mem_q [DEPTH];
  logic [AW-1:0] wptr_q, rptr_q;
  logic [CW-1:0] count_q;
  logic          room, accept, pop;

  assign room    = (count_q <= ROOM_MAX);
  assign accept  = push_i && room;
  assign valid_o = (count_q != '0);
  assign pop     = ready_i && valid_o;
  assign byte_o  = valid_o ? mem_q[rptr_q] : 8'h00;

  always_ff @(posedge clk_i) begin
    if (accept) begin
      for (int k = 0; k < PKT_LEN; k++) begin
        mem_q[wptr_q + AW'(k)] <= pkt_i[k];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q  <= '0;
      rptr_q  <= '0;
      count_q <= '0;
    end else begin
      if (accept) wptr_q <= wptr_q + AW'(PKT_LEN);
      if (pop)    rptr_q <= rptr_q + 1'b1;
      count_q <= count_q + (accept ? PKT_CNT : '0) - CW'(pop);
    end
  end

  p_no_overflow_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= DEPTH_C);
  p_drop_whole_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !room) |=> count_q <= $past(count_q));
  p_accept_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && room && !pop) |=> count_q == $past(count_q) + PKT_CNT);
  p_one_pop_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop && !push_i) |=> count_q == $past(count_q) - 1'b1);
  p_next_avail_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop && count_q > CW'(1)) |=> valid_o);
  p_both_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && room && pop) |=> count_q == $past(count_q) + PKT_CNT - 1'b1);
endmodule

// File: rtl/mouse_pkt_enc.sv
module mouse_pkt_enc
  import mpkt_pkg::*;
#(
  parameter int DELTA_W = 16,
  parameter int DEPTH   = 256
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      evt_valid_i,
  input  logic signed [DELTA_W-1:0] dx_i,
  input  logic signed [DELTA_W-1:0] dy_i,
  input  logic                      btn_left_i,
  input  logic                      btn_mid_i,
  input  logic                      btn_right_i,
  output logic [7:0]                byte_o,
  output logic                      byte_valid_o,
  input  logic                      byte_ready_i
);
  logic [PKT_LEN-1:0][7:0] pkt;

  mpkt_encoder #(.DELTA_W(DELTA_W)) u_enc (
    .dx_i        (dx_i),
    .dy_i        (dy_i),
    .btn_left_i  (btn_left_i),
    .btn_mid_i   (btn_mid_i),
    .btn_right_i (btn_right_i),
    .pkt_o       (pkt)
  );

  mpkt_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (evt_valid_i),
    .pkt_i   (pkt),
    .ready_i (byte_ready_i),
    .byte_o  (byte_o),
    .valid_o (byte_valid_o)
  );

  p_empty_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !byte_valid_o |-> byte_o == 8'h00);
endmodule

// File: tb/mouse_pkt_enc_bench.sv
`timescale 1ns/1ps
module mouse_pkt_enc_bench;
  localparam int DW = 16;

  logic                 clk_i = 1'b0;
  logic                 rst_ni = 1'b0;
  logic                 evt_valid_i = 1'b0;
  logic signed [DW-1:0] dx_i = '0, dy_i = '0;
  logic                 btn_left_i = 1'b0, btn_mid_i = 1'b0, btn_right_i = 1'b0;
  logic [7:0]           byte_o;
  logic                 byte_valid_o;
  logic                 byte_ready_i = 1'b0;

  int n_chk = 0, n_bad = 0;
  logic [7:0] exp_q[$];
  int         pos_q[$];
  bit         done = 1'b0;

  always #10 clk_i = ~clk_i;

  mouse_pkt_enc #(.DELTA_W(DW), .DEPTH(256)) u_mouse_pkt_enc (.*);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] sat_m(input int v);
    if (v > 127) return 8'h7f;
    if (v < -127) return 8'h81;
    return v[7:0];
  endfunction

  function automatic string tag_of(input int p);
    case (p)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      default: return "R5";
    endcase
  endfunction

  function automatic void model_push(input int dx, input int dy, input bit l, input bit m, input bit r);
    if (exp_q.size() <= 251) begin
      exp_q.push_back(8'h87 & ~{5'b0, l, m, r}); pos_q.push_back(0);
      exp_q.push_back(sat_m(dx));  pos_q.push_back(1);
      exp_q.push_back(sat_m(-dy)); pos_q.push_back(2);
      exp_q.push_back(8'h00);      pos_q.push_back(3);
      exp_q.push_back(8'h00);      pos_q.push_back(4);
    end
  endfunction

  task automatic send(input int dx, input int dy, input bit l, input bit m, input bit r);
    @(negedge clk_i);
    evt_valid_i = 1'b1; dx_i = DW'(dx); dy_i = DW'(dy);
    btn_left_i = l; btn_mid_i = m; btn_right_i = r;
    model_push(dx, dy, l, m, r);
    @(negedge clk_i);
    evt_valid_i = 1'b0;
  endtask

  // continuous-ready drain: no gaps allowed (R9), order per R6
  task automatic drain_all();
    while (exp_q.size() > 0) begin
      check(byte_valid_o == 1'b1, "R9", byte_valid_o, 1);
      check(byte_o == exp_q[0], {tag_of(pos_q[0]), "/R6"}, byte_o, exp_q[0]);
      void'(exp_q.pop_front()); void'(pos_q.pop_front());
      byte_ready_i = 1'b1;
      @(negedge clk_i);
    end
    byte_ready_i = 1'b0;
    check(byte_valid_o == 1'b0, "R8", byte_valid_o, 0);
    check(byte_o == 8'h00, "R8", byte_o, 0);
  endtask

  task automatic t_reset();
    rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    check(byte_valid_o == 1'b0, "R1", byte_valid_o, 0);
    check(byte_o == 8'h00, "R1", byte_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  task automatic t_basic();
    send(5, 10, 0, 0, 0);
    send(-3, -7, 1, 0, 0);
    send(0, 0, 0, 1, 0);
    send(1, -1, 0, 0, 1);
    send(-1, 1, 1, 1, 1);
    @(negedge clk_i);
    drain_all();
  endtask

  task automatic t_saturate();
    send(127, -127, 0, 0, 0);
    send(128, 128, 1, 0, 1);
    send(-127, 127, 0, 1, 1);
    send(-128, -128, 1, 1, 0);
    send(200, -300, 0, 0, 0);
    send(32767, -32768, 0, 0, 0);
    send(-32768, 32767, 0, 0, 0);
    drain_all();
  endtask

  task automatic t_empty_ready();
    byte_ready_i = 1'b1;
    repeat (3) @(negedge clk_i);
    check(byte_valid_o == 1'b0, "R8", byte_valid_o, 0);
    check(byte_o == 8'h00, "R8", byte_o, 0);
    byte_ready_i = 1'b0;
    send(9, 9, 0, 0, 0);
    drain_all();
  endtask

  task automatic t_fill_drop();
    for (int i = 0; i < 51; i++) send(i, -i, i[0], i[1], i[2]);
    check(exp_q.size() == 255, "R7", exp_q.size(), 255);
    send(77, 77, 1, 1, 1);  // only one entry free: must be dropped
    drain_all();
  endtask

  task automatic t_concurrent();
    // 251 bytes queued, then strobe + pop together: room judged before pop
    for (int i = 0; i < 50; i++) send(i, i, 0, 0, 0);
    send(3, 3, 0, 0, 0);
    @(negedge clk_i);
    byte_ready_i = 1'b1;
    repeat (4) begin
      check(byte_o == exp_q[0], "R6", byte_o, exp_q[0]);
      void'(exp_q.pop_front()); void'(pos_q.pop_front());
      @(negedge clk_i);
    end
    // 251 now held, so the strobe fits
    check(byte_o == exp_q[0], "R10", byte_o, exp_q[0]);
    void'(exp_q.pop_front()); void'(pos_q.pop_front());
    evt_valid_i = 1'b1; dx_i = 16'sd60; dy_i = -16'sd60;
    btn_left_i = 1'b0; btn_mid_i = 1'b1; btn_right_i = 1'b0;
    model_push(60, -60, 0, 1, 0);
    @(negedge clk_i);
    evt_valid_i = 1'b0; byte_ready_i = 1'b0;
    check(exp_q.size() == 255, "R10", exp_q.size(), 255);
    drain_all();
  endtask

  initial begin
    t_reset();
    t_basic();
    t_saturate();
    t_empty_ready();
    t_fill_drop();
    t_concurrent();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule